// File: doc/BRIEF.md
# Pool Resource Layer Assignment Crossbar

This block decides which display layer feeds each shared pool resource and steers the pixel stream to match. Software never writes the multiplexer selects directly. It first loads a resource-kind identifier into an ID register. It then writes a packed assignment word. Each 4-bit field of that word is a layer code for one resource of that kind, and the word is stored into an internal table entry chosen by the held identifier. Reading the assignment register returns the stored entry for the current identifier, so the table can be inspected.

The table entry of kind 0 drives a pool multiplexer. That multiplexer forwards one of the two layer input streams, as a valid/data pair, to each of the two resource outputs. Register access uses a simple write/read strobe port inside a 4 kB window. Read data comes back one cycle after the read strobe.

Top module: `lpr_router`

## Requirements
- R1: Register selection looks only at address bits 11:9, and bit 12 and bits 8:0 are ignored. Select value 0 is the ID register and select value 1 is the assignment register. Every other select value reads as zero, and writes to it change nothing.
- R2: The ID register stores all 32 written bits and reads them back unchanged.
- R3: A write to the assignment register stores field n (bits 4n+3:4n) of the write data for resources n = 0 and 1 into the table entry selected by the current ID. A read returns that entry in the same field positions.
- R4: Fields 2 to 7 of the assignment register are reserved. They always read as zero, and written values are discarded.
- R5: When the ID is not a valid entry (only ID 0 exists), a write to the assignment register leaves the table unchanged and a read of it returns zero.
- R6: Reset (synchronous, active high) clears the ID to 0 and every table field to code 0. As a result, both outputs carry layer input 1 after reset.
- R7: Code 0 routes a resource output to layer input 1 (`in_vld[0]`, `in_data[15:0]`). Code 1 routes it to layer input 2 (`in_vld[1]`, `in_data[31:16]`). The output's valid and data both come from the chosen input.
- R8: Any code other than 0 or 1 drives that output's valid and data to zero.
- R9: A table write changes routing starting with the cycle after the write edge. A beat presented in the write cycle still uses the old routing, and valid and data of an output always switch together.
- R10: `reg_rdata` updates one cycle after `reg_rd` and holds its value while no read is issued. A read issued in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 13 | Byte address within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| in_vld | input | 2 | Valid of layer inputs 1 and 2 |
| in_data | input | 32 | Layer input data, layer 1 in bits 15:0 |
| out_vld | output | 2 | Valid of resource outputs 0 and 1 |
| out_data | output | 32 | Resource output data, resource 0 in bits 15:0 |

## Verification
A table write and a live beat on the multiplexer can land in the same cycle. The bench holds both inputs active and issues an assignment write. It checks that, before the edge, the outputs still follow the old codes, and that, after the edge, valid and data of the remapped output have moved together to the new layer. A register read and a write to the same register can also coincide. The bench strobes both together and requires the returned word to be the value from before the write, with the new value visible on the next read.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

    localparam int ADDR_W   = 13;
    localparam int DATA_W   = 32;
    localparam int SLOT_W   = 4;
    localparam int SLOT_CNT = DATA_W / SLOT_W;
    localparam int SEL_LO   = 9;
    localparam int SEL_W    = 3;

    localparam logic [SEL_W-1:0] SEL_ID     = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ASSIGN = 3'd1;

    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_ID     = 2'd1,
        REG_ASSIGN = 2'd2
    } reg_sel_e;

    typedef logic [SLOT_W-1:0] layer_code_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr);
        logic [SEL_W-1:0] s;
        s = addr[SEL_LO +: SEL_W];
        if (s == SEL_ID)
            return REG_ID;
        else if (s == SEL_ASSIGN)
            return REG_ASSIGN;
        else
            return REG_NONE;
    endfunction

endpackage

// File: rtl/lpr_regdec.sv
module lpr_regdec
    import lpr_pkg::*;
(
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    output reg_sel_e          sel,
    output logic              wr_id,
    output logic              wr_asg
);

    always_comb begin
        sel    = decode_sel(reg_addr);
        wr_id  = reg_wr && (sel == REG_ID);
        wr_asg = reg_wr && (sel == REG_ASSIGN);
    end

endmodule

// File: rtl/lpr_assign_table.sv
module lpr_assign_table
    import lpr_pkg::*;
#(
    parameter int NUM_KINDS = 1,
    parameter int NUM_RES   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_id,
    input  logic                      wr_asg,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         id_q,
    output logic [DATA_W-1:0]         asg_rd,
    output logic [NUM_RES*SLOT_W-1:0] route_codes
);

    localparam int ENTRY_W = NUM_RES * SLOT_W;

    logic [NUM_KINDS-1:0][NUM_RES-1:0][SLOT_W-1:0] tbl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q  <= '0;
            tbl_q <= '0;
        end else begin
            if (wr_id)
                id_q <= wdata;
            for (int k = 0; k < NUM_KINDS; k++) begin
                if (wr_asg && (id_q == DATA_W'(k))) begin
                    for (int n = 0; n < NUM_RES; n++)
                        tbl_q[k][n] <= wdata[n*SLOT_W +: SLOT_W];
                end
            end
        end
    end

    always_comb begin
        asg_rd = '0;
        for (int k = 0; k < NUM_KINDS; k++) begin
            if (id_q == DATA_W'(k))
                asg_rd[ENTRY_W-1:0] = tbl_q[k];
        end
    end

    assign route_codes = tbl_q[0];

    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_asg |=> $stable(tbl_q)) else $error("table changed without write"); // R3

    AST_BAD_ID_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_asg && (id_q >= DATA_W'(NUM_KINDS))) |=> $stable(tbl_q))
        else $error("write with bad id altered table"); // R5

    AST_RESET_ROUTE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (route_codes == '0 && id_q == '0))
        else $error("reset state wrong"); // R6

endmodule

// File: rtl/lpr_pool_mux.sv
module lpr_pool_mux
    import lpr_pkg::*;
#(
    parameter int NUM_RES    = 2,
    parameter int NUM_LAYERS = 2,
    parameter int PIX_W      = 16
) (
    input  logic [NUM_RES*SLOT_W-1:0]   route_codes,
    input  logic [NUM_LAYERS-1:0]       in_vld,
    input  logic [NUM_LAYERS*PIX_W-1:0] in_data,
    output logic [NUM_RES-1:0]          out_vld,
    output logic [NUM_RES*PIX_W-1:0]    out_data
);

    for (genvar n = 0; n < NUM_RES; n++) begin : g_res
        layer_code_t code;
        assign code = route_codes[n*SLOT_W +: SLOT_W];

        always_comb begin
            out_vld[n]                 = 1'b0;
            out_data[n*PIX_W +: PIX_W] = '0;
            for (int l = 0; l < NUM_LAYERS; l++) begin
                if (code == SLOT_W'(l)) begin
                    out_vld[n]                 = in_vld[l];
                    out_data[n*PIX_W +: PIX_W] = in_data[l*PIX_W +: PIX_W];
                end
            end
        end
    end

endmodule

// File: rtl/lpr_router.sv
module lpr_router
    import lpr_pkg::*;
#(
    parameter int NUM_KINDS  = 1,
    parameter int NUM_RES    = 2,
    parameter int NUM_LAYERS = 2,
    parameter int PIX_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [12:0]                   reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [NUM_LAYERS-1:0]         in_vld,
    input  logic [NUM_LAYERS*PIX_W-1:0]   in_data,
    output logic [NUM_RES-1:0]            out_vld,
    output logic [NUM_RES*PIX_W-1:0]      out_data
);

    reg_sel_e                  sel;
    logic                      wr_id;
    logic                      wr_asg;
    logic [DATA_W-1:0]         id_q;
    logic [DATA_W-1:0]         asg_rd;
    logic [NUM_RES*SLOT_W-1:0] route_codes;
    logic [DATA_W-1:0]         rd_mux;

    lpr_regdec u_dec (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .sel      (sel),
        .wr_id    (wr_id),
        .wr_asg   (wr_asg)
    );

    lpr_assign_table #(
        .NUM_KINDS (NUM_KINDS),
        .NUM_RES   (NUM_RES)
    ) u_tbl (
        .clk         (clk),
        .rst         (rst),
        .wr_id       (wr_id),
        .wr_asg      (wr_asg),
        .wdata       (reg_wdata),
        .id_q        (id_q),
        .asg_rd      (asg_rd),
        .route_codes (route_codes)
    );

    lpr_pool_mux #(
        .NUM_RES    (NUM_RES),
        .NUM_LAYERS (NUM_LAYERS),
        .PIX_W      (PIX_W)
    ) u_mux (
        .route_codes (route_codes),
        .in_vld      (in_vld),
        .in_data     (in_data),
        .out_vld     (out_vld),
        .out_data    (out_data)
    );

    always_comb begin
        unique case (sel)
            REG_ID:     rd_mux = id_q;
            REG_ASSIGN: rd_mux = asg_rd;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end

    AST_SEL_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_id, wr_asg})) else $error("two registers written at once"); // R1

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata)) else $error("read data moved without read"); // R10

    AST_VLD_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (|out_vld) |-> (|in_vld)) else $error("output valid without any input valid"); // R7

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && sel == REG_ASSIGN) |=> (reg_rdata[DATA_W-1:NUM_RES*SLOT_W] == '0))
        else $error("reserved fields non-zero"); // R4

endmodule

// File: tb/lpr_router_tb.sv
module lpr_router_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_rd;
    logic [12:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [1:0]  in_vld;
    logic [31:0] in_data;
    logic [1:0]  out_vld;
    logic [31:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    lpr_router u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .in_vld    (in_vld),
        .in_data   (in_data),
        .out_vld   (out_vld),
        .out_data  (out_data)
    );

    typedef struct packed {
        logic        is_wr;
        logic [3:0]  req;
        logic [12:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd6, 13'h0000, 32'h0000_0000},  // R6 id after reset
        '{1'b0, 4'd6, 13'h0200, 32'h0000_0000},  // R6 table after reset
        '{1'b1, 4'd3, 13'h0200, 32'hFFFF_FF10},  // R3 slot0=0 slot1=1
        '{1'b0, 4'd4, 13'h0200, 32'h0000_0010},  // R4 reserved cleared
        '{1'b1, 4'd1, 13'h13FF, 32'h0000_0001},  // R1 bit12, low bits ignored
        '{1'b0, 4'd1, 13'h0200, 32'h0000_0001},  // R1
        '{1'b1, 4'd2, 13'h0000, 32'hA5C3_0005},  // R2 id=bad
        '{1'b0, 4'd2, 13'h1000, 32'hA5C3_0005},  // R2 full readback, bit12 ignored
        '{1'b0, 4'd5, 13'h0200, 32'h0000_0000},  // R5 bad id reads zero
        '{1'b1, 4'd5, 13'h0200, 32'h0000_0011},  // R5 dropped write
        '{1'b1, 4'd2, 13'h0000, 32'h0000_0000},  // R2 id=0
        '{1'b0, 4'd5, 13'h0200, 32'h0000_0001},  // R5 table unchanged
        '{1'b1, 4'd1, 13'h0400, 32'h0000_DEAD},  // R1 unmapped select
        '{1'b0, 4'd1, 13'h0400, 32'h0000_0000},  // R1 unmapped reads zero
        '{1'b0, 4'd1, 13'h0000, 32'h0000_0000},  // R1 id untouched
        '{1'b0, 4'd1, 13'h0E00, 32'h0000_0000}   // R1 top select reads zero
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_addr = '0; reg_wdata = '0; in_vld = '0; in_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R6: both resources take layer 1 after reset
        in_vld = 2'b01; in_data = {16'hBBBB, 16'hAAAA};
        #1;
        check("R6 vld", 64'(out_vld), 64'(2'b11));
        check("R6 data", 64'(out_data), 64'({16'hAAAA, 16'hAAAA}));

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr)
                do_write(VEC[i].addr, VEC[i].data);
            else begin
                do_read(VEC[i].addr, rd);
                check($sformatf("R%0d vec%0d", VEC[i].req, i), 64'(rd), 64'(VEC[i].data));
            end
        end

        // R7: table now slot0=1 slot1=0 -> out0 from layer 2, out1 from layer 1
        @(negedge clk);
        in_vld = 2'b10; in_data = {16'h2222, 16'h1111};
        #1;
        check("R7 vld", 64'(out_vld), 64'(2'b01));
        check("R7 data", 64'(out_data), 64'({16'h1111, 16'h2222}));

        // R8: slot1 gets code 2 -> output 1 silent
        do_write(13'h0200, 32'h0000_0020);
        in_vld = 2'b11; in_data = {16'hBBBB, 16'hAAAA};
        #1;
        check("R8 vld", 64'(out_vld), 64'(2'b01));
        check("R8 data", 64'(out_data), 64'({16'h0000, 16'hAAAA}));

        // R9: write and live beat in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 13'h0200; reg_wdata = 32'h0000_0010;
        #1;
        check("R9 old vld", 64'(out_vld), 64'(2'b01));
        check("R9 old data", 64'(out_data), 64'({16'h0000, 16'hAAAA}));
        @(negedge clk);
        reg_wr = 1'b0;
        check("R9 new vld", 64'(out_vld), 64'(2'b11));
        check("R9 new data", 64'(out_data), 64'({16'hBBBB, 16'hAAAA}));

        // R10: read and write in one cycle return the old value
        @(negedge clk);
        reg_rd = 1'b1; reg_wr = 1'b1; reg_addr = 13'h0200; reg_wdata = 32'h0000_0021;
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0;
        check("R10 read-before-write", 64'(reg_rdata), 64'(32'h10));
        repeat (2) @(negedge clk);
        check("R10 hold", 64'(reg_rdata), 64'(32'h10));
        do_read(13'h0200, rd);
        check("R3 new entry", 64'(rd), 64'(32'h21));

        // R6: reset mid-run
        do_write(13'h0000, 32'h0000_0003);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R6 rdata reset", 64'(reg_rdata), 64'(0));
        do_read(13'h0000, rd);
        check("R6 id reset", 64'(rd), 64'(0));
        do_read(13'h0200, rd);
        check("R6 table reset", 64'(rd), 64'(0));
        check("R6 route", 64'(out_data), 64'({16'hAAAA, 16'hAAAA}));

        finish_run();
    end

endmodule